// File: doc/BRIEF.md
# Thresholded Event Counter Pair

This block is a small performance-monitoring unit with two independent counters. A vector of event lines arrives every cycle, organised as eight groups of eight lines each. Each counter has a control register that picks one group with an event-select code and a subset of its lines with a unit mask. The number of selected lines that are high forms a per-cycle increment from 0 to 8. A threshold stage turns that increment into a qualified event. An optional rising-edge stage follows it. While the counter's enable bit is set, the result is added to a 48-bit counter.

When a counter wraps past its top value, it can record the overflow in a shared status register and pulse an exception output. The overflow flags are cleared by writing ones to them. A write-only bit in each control register zeroes its counter. Software reaches all state through a flat register port. Writes take effect at the clock edge on which `regWr` is high. Reads are combinational from `regAddr`.

Register map (word addresses): 0 is the status register. 1 and 2 are the control registers of counters 0 and 1. 3 and 4 are the counters 0 and 1. Any other address reads as zero.

Top module: `pmon_pair_top`

## Requirements
- R1: After reset, every register reads zero and `excOut` is low.
- R2: In the status register, bit k is the overflow flag of counter k. Writing 1 to bit k clears it, and writing 0 leaves it unchanged. Bits 63:2 read zero.
- R3: The control register fields are as follows:
  - event select at 7:0
  - unit mask at 15:8
  - edge mode at 18
  - overflow reporting at 20
  - enable at 22
  - threshold at 28:24

  Writing all ones and reading back gives 0x1F54FFFF. Bit 17 and all other bits read zero.
- R4: The increment is the count of ones in (group[evSel] AND umask), where group g is `evtLines[8g+7:8g]`. An event select of 8 or more gives an increment of 0.
- R5: With threshold 0 and edge mode off, an enabled counter adds the raw increment on each clock edge. The value read after an edge includes the events presented in the cycle before it.
- R6: With a nonzero threshold, the qualified event is high when the increment is greater than or equal to the threshold. With edge mode off, the counter adds 1 for each such cycle.
- R7: With edge mode on, the counter adds 1 only when the qualified event rises from 0 to 1 between consecutive cycles. With threshold 0, "qualified" means the increment is nonzero.
- R8: While enable is 0, the counter holds its value whatever the events are.
- R9: A control write with bit 17 set zeroes that counter at the write's clock edge. This overrides any increment on that edge.
- R10: Counters wrap modulo 2^CNT_W. With overflow reporting on, a wrap sets the counter's status flag, and `excOut` is high for exactly the one cycle in which the wrapped value first reads. With reporting off, a wrap sets no flag and raises no pulse.
- R11: If an overflow sets a status flag on the same edge that a write clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWdata | input | 64 | Register write data |
| evtLines | input | 64 | Event lines, 8 groups of 8 |
| rdData | output | 64 | Combinational read data for `regAddr` |
| excOut | output | 1 | One-cycle overflow exception pulse |

## Verification
The event path has one register on it: the increment from the events held during a cycle shows up in the counter read just after the next rising edge. Status flags, the exception pulse and the counter clear from a bit-17 write are likewise due on the edge that ends the cycle of stimulus. The bench therefore applies all stimulus at falling edges and counts the rising edges that separate stimulus from result. It reads and samples just after a falling edge, so each expected value is compared one half period after the edge that produced it. The bench runs with a narrow counter so that wraparound is reached in tens of cycles.

// File: rtl/pmon_pkg.sv
package pmon_pkg;

  // Width of one event group and of the unit mask.
  localparam int LINE_W = 8;
  localparam int CTL_W  = 32;

  // Control register bit positions.
  localparam int EVSEL_LO = 0;
  localparam int UMASK_LO = 8;
  localparam int CLR_BIT  = 17;
  localparam int EDGE_BIT = 18;
  localparam int OVEN_BIT = 20;
  localparam int EN_BIT   = 22;
  localparam int THR_LO   = 24;
  localparam int THR_W    = 5;

  typedef struct packed {
    logic [THR_W-1:0]  thresh;
    logic              enable;
    logic              ovfEn;
    logic              edgeMode;
    logic [LINE_W-1:0] umask;
    logic [7:0]        evSel;
  } ctl_fields_t;

  // Strobe bundle from control to datapath, one per counter.
  typedef struct packed {
    ctl_fields_t cfg;
    logic        clrCnt;
  } cnt_strobe_t;

  function automatic ctl_fields_t unpackCtl(input logic [CTL_W-1:0] w);
    ctl_fields_t f;
    f.evSel    = w[EVSEL_LO +: 8];
    f.umask    = w[UMASK_LO +: LINE_W];
    f.edgeMode = w[EDGE_BIT];
    f.ovfEn    = w[OVEN_BIT];
    f.enable   = w[EN_BIT];
    f.thresh   = w[THR_LO +: THR_W];
    return f;
  endfunction

  function automatic logic [CTL_W-1:0] packCtl(input ctl_fields_t f);
    logic [CTL_W-1:0] w;
    w = '0;
    w[EVSEL_LO +: 8]      = f.evSel;
    w[UMASK_LO +: LINE_W] = f.umask;
    w[EDGE_BIT]           = f.edgeMode;
    w[OVEN_BIT]           = f.ovfEn;
    w[EN_BIT]             = f.enable;
    w[THR_LO +: THR_W]    = f.thresh;
    return w;
  endfunction

endpackage

// File: rtl/pmon_ctrl.sv
module pmon_ctrl
  import pmon_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int CNT_W   = 48,
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              regWr,
  input  logic [ADDR_W-1:0]                 regAddr,
  input  logic [DATA_W-1:0]                 regWdata,
  input  logic [NUM_CNT-1:0]                ovfCarry,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]     cntVal,
  output cnt_strobe_t [NUM_CNT-1:0]         strobeBus,
  output logic [DATA_W-1:0]                 rdData,
  output logic                              excOut
);

  localparam logic [ADDR_W-1:0] STAT_ADDR = '0;

  ctl_fields_t [NUM_CNT-1:0] ctlReg;
  logic [NUM_CNT-1:0]        statusBits;
  logic [NUM_CNT-1:0]        wrCtl;
  logic [NUM_CNT-1:0]        ovfReport;
  logic [NUM_CNT-1:0]        clrMask;
  logic                      wrStat;

  assign wrStat = regWr && (regAddr == STAT_ADDR);

  // Per-counter decode: control write select, clear strobe, report gating.
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_dec
    assign wrCtl[i]            = regWr && (regAddr == ADDR_W'(1 + i));
    assign strobeBus[i].cfg    = ctlReg[i];
    assign strobeBus[i].clrCnt = wrCtl[i] && regWdata[CLR_BIT];
    assign ovfReport[i]        = ovfCarry[i] && ctlReg[i].ovfEn;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctlReg[i] <= '0;
      end else if (wrCtl[i]) begin
        ctlReg[i] <= unpackCtl(regWdata[CTL_W-1:0]);
      end
    end
  end

  // Write-one-to-clear, new overflow wins over a clear on the same edge.
  assign clrMask = wrStat ? regWdata[NUM_CNT-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusBits <= '0;
      excOut     <= 1'b0;
    end else begin
      statusBits <= (statusBits & ~clrMask) | ovfReport;
      excOut     <= |ovfReport;
    end
  end

  // Combinational read mux.
  always_comb begin
    rdData = '0;
    if (regAddr == STAT_ADDR) begin
      rdData[NUM_CNT-1:0] = statusBits;
    end
    for (int i = 0; i < NUM_CNT; i++) begin
      if (regAddr == ADDR_W'(1 + i)) begin
        rdData[CTL_W-1:0] = packCtl(ctlReg[i]);
      end
      if (regAddr == ADDR_W'(1 + NUM_CNT + i)) begin
        rdData[CNT_W-1:0] = cntVal[i];
      end
    end
  end

endmodule

// File: rtl/pmon_dpath.sv
module pmon_dpath
  import pmon_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int NUM_GRP = 8,
  parameter int CNT_W   = 48,
  localparam int EVT_W  = NUM_GRP * LINE_W,
  localparam int INC_W  = $clog2(LINE_W + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [EVT_W-1:0]              evtLines,
  input  cnt_strobe_t [NUM_CNT-1:0]     strobeBus,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cntVal,
  output logic [NUM_CNT-1:0]            ovfCarry
);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    ctl_fields_t       cfg;
    logic [LINE_W-1:0] grpLines;
    logic [INC_W-1:0]  inc;
    logic              hitRaw;
    logic              prevHit;
    logic              qualHit;
    logic [INC_W-1:0]  step;
    logic [CNT_W:0]    sum;

    assign cfg = strobeBus[i].cfg;

    // Group select: codes beyond the last group select nothing.
    always_comb begin
      grpLines = '0;
      for (int g = 0; g < NUM_GRP; g++) begin
        if (cfg.evSel == 8'(g)) begin
          grpLines = evtLines[g*LINE_W +: LINE_W];
        end
      end
    end

    // Number of masked lines that are high.
    always_comb begin
      inc = '0;
      for (int b = 0; b < LINE_W; b++) begin
        inc = inc + INC_W'(grpLines[b] & cfg.umask[b]);
      end
    end

    // Threshold stage, then the optional rising-edge stage.
    always_comb begin
      if (cfg.thresh == '0) begin
        hitRaw = (inc != '0);
      end else begin
        hitRaw = (THR_W'(inc) >= cfg.thresh);
      end
      qualHit = cfg.edgeMode ? (hitRaw && !prevHit) : hitRaw;
      if ((cfg.thresh == '0) && !cfg.edgeMode) begin
        step = inc;
      end else begin
        step = INC_W'(qualHit);
      end
      sum = {1'b0, cntVal[i]} + (CNT_W+1)'(step);
    end

    assign ovfCarry[i] = sum[CNT_W] && cfg.enable && !strobeBus[i].clrCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntVal[i] <= '0;
        prevHit   <= 1'b0;
      end else begin
        prevHit <= hitRaw;
        if (strobeBus[i].clrCnt) begin
          cntVal[i] <= '0;
        end else if (cfg.enable) begin
          cntVal[i] <= sum[CNT_W-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/pmon_pair_top.sv
module pmon_pair_top
  import pmon_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int NUM_GRP = 8,
  parameter int CNT_W   = 48,
  parameter int DATA_W  = 64,
  localparam int ADDR_W = $clog2(2 * NUM_CNT + 1),
  localparam int EVT_W  = NUM_GRP * LINE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [EVT_W-1:0]  evtLines,
  output logic [DATA_W-1:0] rdData,
  output logic              excOut
);

  cnt_strobe_t [NUM_CNT-1:0]     strobeBus;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal;
  logic [NUM_CNT-1:0]            ovfCarry;

  pmon_ctrl #(
    .NUM_CNT(NUM_CNT),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .ovfCarry (ovfCarry),
    .cntVal   (cntVal),
    .strobeBus(strobeBus),
    .rdData   (rdData),
    .excOut   (excOut)
  );

  pmon_dpath #(
    .NUM_CNT(NUM_CNT),
    .NUM_GRP(NUM_GRP),
    .CNT_W  (CNT_W)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .evtLines (evtLines),
    .strobeBus(strobeBus),
    .cntVal   (cntVal),
    .ovfCarry (ovfCarry)
  );

endmodule

// File: rtl/pmon_pair_chk.sv
module pmon_pair_chk
  import pmon_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int CNT_W   = 48,
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 3
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [ADDR_W-1:0]             regAddr,
  input logic [DATA_W-1:0]             rdData,
  input logic                          excOut,
  input cnt_strobe_t [NUM_CNT-1:0]     strobeBus,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cntVal
);

  logic [NUM_CNT-1:0][CNT_W-1:0] prevCnt;
  logic [NUM_CNT-1:0]            prevRun;
  logic [NUM_CNT-1:0]            wrapNow;
  logic                          ctlSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCnt <= '0;
      prevRun <= '0;
    end else begin
      prevCnt <= cntVal;
      for (int i = 0; i < NUM_CNT; i++) begin
        prevRun[i] <= strobeBus[i].cfg.enable && strobeBus[i].cfg.ovfEn
                      && !strobeBus[i].clrCnt;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      wrapNow[i] = prevRun[i] && (cntVal[i] < prevCnt[i]);
    end
  end

  assign ctlSel = (regAddr >= ADDR_W'(1)) && (regAddr <= ADDR_W'(NUM_CNT));

  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == '0) |-> (rdData[DATA_W-1:NUM_CNT] == '0)); // R2

  AST_CTL_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctlSel |-> (rdData[DATA_W-1:29] == '0 && rdData[23] == 1'b0 && rdData[21] == 1'b0
                && rdData[19] == 1'b0 && rdData[17:16] == 2'b00)); // R3

  AST_EXC_NEEDS_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    excOut |-> (|wrapNow)); // R10

  AST_WRAP_RAISES_EXC: assert property (@(posedge clk) disable iff (!rstN)
    (|wrapNow) |-> excOut); // R10

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (!strobeBus[i].cfg.enable && !strobeBus[i].clrCnt) |=> $stable(cntVal[i])); // R8

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
      strobeBus[i].clrCnt |=> (cntVal[i] == '0)); // R9
  end

endmodule

bind pmon_pair_top pmon_pair_chk #(
  .NUM_CNT(NUM_CNT),
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .rdData   (rdData),
  .excOut   (excOut),
  .strobeBus(strobeBus),
  .cntVal   (cntVal)
);

// File: tb/pmon_pair_top_tb_top.sv
module pmon_pair_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;

  localparam logic [2:0] A_STAT = 3'd0;
  localparam logic [2:0] A_CTL0 = 3'd1;
  localparam logic [2:0] A_CTL1 = 3'd2;
  localparam logic [2:0] A_CNT0 = 3'd3;
  localparam logic [2:0] A_CNT1 = 3'd4;

  localparam logic [63:0] B_CLR  = 64'h0002_0000;
  localparam logic [63:0] B_EDGE = 64'h0004_0000;
  localparam logic [63:0] B_OVEN = 64'h0010_0000;
  localparam logic [63:0] B_EN   = 64'h0040_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [63:0] regWdata = '0;
  logic [63:0] evtLines = '0;
  logic [63:0] rdData;
  logic        excOut;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmon_pair_top #(.CNT_W(CNT_W)) dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .regWr   (regWr),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .evtLines(evtLines),
    .rdData  (rdData),
    .excOut  (excOut)
  );

  function automatic logic [63:0] ctlWord(input logic [7:0] sel, input logic [7:0] um,
                                          input logic [4:0] thr, input logic [63:0] flags);
    return flags | {35'd0, thr, 24'd0} | {48'd0, um, sel};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [63:0] d);
    regAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic runCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setGroup(input int g, input logic [7:0] v);
    evtLines[g*8 +: 8] = v;
  endtask

  task automatic testReset();
    logic [63:0] d;
    regRead(A_STAT, d); chk("R1 status", d, 64'd0);
    regRead(A_CTL0, d); chk("R1 ctl0", d, 64'd0);
    regRead(A_CTL1, d); chk("R1 ctl1", d, 64'd0);
    regRead(A_CNT0, d); chk("R1 cnt0", d, 64'd0);
    regRead(A_CNT1, d); chk("R1 cnt1", d, 64'd0);
    chk("R1 exc", {63'd0, excOut}, 64'd0);
  endtask

  task automatic testCtlReadback();
    logic [63:0] d;
    regWrite(A_CTL1, '1);
    regRead(A_CTL1, d); chk("R3 readback", d, 64'h1F54_FFFF);
    regWrite(A_CTL1, 64'd0);
    regRead(A_CNT1, d); chk("R3 cnt1 untouched", d, 64'd0);
  endtask

  task automatic testRawCount();
    logic [63:0] d;
    regWrite(A_CTL0, ctlWord(8'd3, 8'h0F, 5'd0, B_EN));
    evtLines = '1;
    setGroup(3, 8'b0011_0110);   // masked popcount 2
    runCycles(5);
    evtLines = '0;
    regRead(A_CNT0, d); chk("R4 R5 raw sum", d, 64'd10);
  endtask

  task automatic testDisabled();
    logic [63:0] d;
    regWrite(A_CTL0, ctlWord(8'd3, 8'hFF, 5'd0, 64'd0));
    evtLines = '1;
    runCycles(5);
    evtLines = '0;
    regRead(A_CNT0, d); chk("R8 hold while disabled", d, 64'd10);
  endtask

  task automatic testClear();
    logic [63:0] d;
    setGroup(3, 8'hFF);
    regWrite(A_CTL0, ctlWord(8'd3, 8'hFF, 5'd0, B_EN | B_CLR));
    regRead(A_CNT0, d); chk("R9 clear beats increment", d, 64'd0);
    runCycles(2);
    evtLines = '0;
    regRead(A_CNT0, d); chk("R9 count after clear", d, 64'd16);
    regRead(A_CTL0, d); chk("R9 bit17 reads zero", d & B_CLR, 64'd0);
  endtask

  task automatic testThreshold();
    logic [63:0] d;
    logic [7:0] pat [5] = '{8'h03, 8'h07, 8'h1F, 8'h01, 8'hFF};
    regWrite(A_CTL0, ctlWord(8'd3, 8'hFF, 5'd3, B_EN | B_CLR));
    foreach (pat[k]) begin
      setGroup(3, pat[k]);
      @(negedge clk);
    end
    evtLines = '0;
    @(negedge clk);
    regRead(A_CNT0, d); chk("R6 threshold 3", d, 64'd3);
  endtask

  task automatic testEdge();
    logic [63:0] d;
    logic [7:0] pat [9] = '{8'h01, 8'h01, 8'h01, 8'h00, 8'h03, 8'h03, 8'h00, 8'h00, 8'h01};
    regWrite(A_CTL0, ctlWord(8'd3, 8'hFF, 5'd1, B_EN | B_EDGE | B_CLR));
    foreach (pat[k]) begin
      setGroup(3, pat[k]);
      @(negedge clk);
    end
    evtLines = '0;
    @(negedge clk);
    regRead(A_CNT0, d); chk("R7 rising edges", d, 64'd3);
  endtask

  task automatic testBadSelect();
    logic [63:0] d;
    regWrite(A_CTL0, ctlWord(8'd9, 8'hFF, 5'd0, B_EN | B_CLR));
    evtLines = '1;
    runCycles(4);
    evtLines = '0;
    regRead(A_CNT0, d); chk("R4 select out of range", d, 64'd0);
  endtask

  task automatic testOverflow();
    logic [63:0] d;
    regWrite(A_CTL0, ctlWord(8'd0, 8'hFF, 5'd0, B_EN | B_OVEN | B_CLR));
    setGroup(0, 8'hFF);
    runCycles(31);
    regRead(A_CNT0, d); chk("R10 pre-wrap count", d, 64'd248);
    regRead(A_STAT, d); chk("R10 no flag before wrap", d, 64'd0);
    chk("R10 no pulse before wrap", {63'd0, excOut}, 64'd0);
    @(negedge clk);
    evtLines = '0;
    chk("R10 pulse on wrap", {63'd0, excOut}, 64'd1);
    regRead(A_CNT0, d); chk("R10 wrapped value", d, 64'd0);
    regRead(A_STAT, d); chk("R10 flag set", d, 64'd1);
    @(negedge clk);
    chk("R10 pulse one cycle", {63'd0, excOut}, 64'd0);
  endtask

  task automatic testW1C();
    logic [63:0] d;
    regWrite(A_STAT, 64'd0);
    regRead(A_STAT, d); chk("R2 write zero keeps flag", d, 64'd1);
    regWrite(A_STAT, 64'd1);
    regRead(A_STAT, d); chk("R2 write one clears", d, 64'd0);
  endtask

  task automatic testSetWins();
    logic [63:0] d;
    regWrite(A_CTL0, ctlWord(8'd0, 8'hFF, 5'd0, B_EN | B_OVEN | B_CLR));
    setGroup(0, 8'hFF);
    runCycles(31);
    regWr = 1'b1; regAddr = A_STAT; regWdata = 64'd1;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
    evtLines = '0;
    chk("R11 pulse", {63'd0, excOut}, 64'd1);
    regRead(A_STAT, d); chk("R11 set beats clear", d, 64'd1);
  endtask

  task automatic testNoReport();
    logic [63:0] d;
    int pulses;
    pulses = 0;
    regWrite(A_CTL0, 64'd0);
    regWrite(A_STAT, 64'd3);
    regWrite(A_CTL1, ctlWord(8'd1, 8'hFF, 5'd0, B_EN | B_CLR));
    setGroup(1, 8'hFF);
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      if (excOut) pulses++;
    end
    evtLines = '0;
    chk("R10 no pulse when reporting off", 64'(pulses), 64'd0);
    regRead(A_CNT1, d); chk("R10 cnt1 wrapped", d, 64'd0);
    regRead(A_STAT, d); chk("R10 no flag when reporting off", d, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCtlReadback();
    testRawCount();
    testDisabled();
    testClear();
    testThreshold();
    testEdge();
    testBadSelect();
    testOverflow();
    testW1C();
    testSetWins();
    testNoReport();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule